// File: doc/BRIEF.md
# Thermometer to Gray Code Decoder

This block sits behind a bank of clocked comparators in a parallel converter. It takes the comparator outputs as a thermometer word and produces a registered Gray-coded sample together with an overrange flag. The word is cleaned of isolated bubbles by a three-input majority vote. The cleaned word is then cut into equal columns. Each column finds its own one-to-zero transition and encodes it into the low code bits. A priority stage picks the highest active column, and that column's index forms the upper code bits.

The thermometer input holds one bit per comparator, with bit 0 as the lowest threshold. The top bit is the extra comparator placed above full scale. Comparator data is captured on the falling clock edge. Column results are held on the rising edge, and the Gray output is updated on the next falling edge. A sample therefore reaches the outputs one full clock period after it is taken.

Top module: `therm_gray_dec`

## Requirements
- R1: The output is the Gray code of the binary sample value b, computed as b XOR (b >> 1). Binary 255 gives 10000000, binary 128 gives 11000000, binary 127 gives 01000000 and binary 0 gives 00000000.
- R2: For a clean thermometer word, the sample value equals the number of consecutive ones counted upward from bit 0 among bits 0 to 254. Bit i is set when the input lies above threshold i+1.
- R3: The four 64-threshold columns join without error. The codes 63, 64, 127, 128, 191 and 192 each decode exactly, with the column index supplying the two upper bits.
- R4: The overrange output is 1 when bit 255 and the full-scale word are both set, and the data output is then 10000000. If bit 255 is set but bit 254 is clear, the bit is treated as an isolated bubble: the overrange output stays 0 and the code is unaffected.
- R5: A true value of C with a single zero at bit position j, where j is at most C-3, decodes exactly to C.
- R6: A true value of C with a single stray one at bit position j, where j is at least C+2, decodes exactly to C.
- R7: A single faulty comparator next to the transition moves the result by no more than 1 LSB. A zero at bit C-2 gives C-1, and a stray one at bit C+1 gives C+1.
- R8: A word present at a falling edge reaches the outputs at the next falling edge. In between, the outputs still show the previous sample.
- R9: A synchronous active-high reset clears the data output and the overrange output to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock. Captures on the falling edge, holds columns on the rising edge. |
| rst | input | 1 | Synchronous active-high reset. |
| therm_in | input | 256 | Comparator word. Bit 0 is the lowest threshold, bit 255 is the overrange comparator. |
| gray_out | output | 8 | Registered Gray-coded sample. |
| ovr_out | output | 1 | Registered overrange flag. |

## Verification
The bench builds the block with its default parameters: six code bits per column and two column-select bits. This gives 256 comparators, so every code and all three column seams are reachable. The vectors include clean words at each seam and at both ends of the scale. They also include bubbles at each legal distance from the transition, the two faulty-comparator cases that border the transition, and both settings of the overrange comparator. Directed cases cover one-cycle latency, reset behaviour, and the literal Gray values for four reference codes.

// File: rtl/therm_gray_pkg.sv
package therm_gray_pkg;

    localparam int DEF_COL_BITS = 6;
    localparam int DEF_SEL_BITS = 2;

    // three-input majority
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/tg_bubble_fix.sv
module tg_bubble_fix #(
    parameter int W = 257
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] fixed
);
    import therm_gray_pkg::*;

    // padded view: one below the vector, zero above
    logic [W+1:0] padded;
    assign padded = {1'b0, raw, 1'b1};

    genvar j;
    generate
        for (j = 0; j < W; j++) begin : g_vote
            assign fixed[j] = maj3(padded[j], padded[j+1], padded[j+2]);
        end
    endgenerate

    // a word with no bubbles must pass through untouched
    always_comb begin
        if ((((raw + W'(1)) & raw) == '0)) begin
            // R5
            clean_pass_chk: assert (fixed == raw)
                else $error("clean word altered by bubble vote");
        end
    end

endmodule

// File: rtl/tg_col_enc.sv
module tg_col_enc #(
    parameter int COL_BITS = 6,
    localparam int SZ = 1 << COL_BITS
) (
    input  logic [SZ-1:0]       slice,
    input  logic                above,
    output logic [COL_BITS-1:0] code,
    output logic                active
);
    logic [SZ:0]   ext;
    logic [SZ-1:0] hot;

    assign ext = {above, slice};
    assign hot = slice & ~ext[SZ:1];

    always_comb begin
        code = '0;
        for (int k = 0; k < SZ; k++) begin
            if (hot[k]) code = code | COL_BITS'(k);
        end
    end

    assign active = |hot;

    always_comb begin
        if ($onehot(hot)) begin
            // R3
            col_code_chk: assert (slice[code] && !ext[int'(code) + 1])
                else $error("column code does not point at the transition");
        end
    end

endmodule

// File: rtl/tg_col_pick.sv
module tg_col_pick #(
    parameter int COL_BITS = 6,
    parameter int SEL_BITS = 2,
    localparam int NCOL   = 1 << SEL_BITS,
    localparam int CODE_W = COL_BITS + SEL_BITS
) (
    input  logic [NCOL-1:0]          act,
    input  logic [NCOL*COL_BITS-1:0] codes,
    input  logic                     ovr,
    output logic [CODE_W-1:0]        gray
);
    logic [SEL_BITS-1:0] sel;
    logic [CODE_W-1:0]   bin;

    // later (higher) columns override earlier ones
    always_comb begin
        sel = '0;
        for (int c = 0; c < NCOL; c++) begin
            if (act[c]) sel = SEL_BITS'(c);
        end
    end

    always_comb begin
        if (ovr) bin = '1;
        else     bin = {sel, codes[int'(sel)*COL_BITS +: COL_BITS]};
    end

    assign gray = bin ^ (bin >> 1);

    always_comb begin
        if (!ovr && (|act)) begin
            // R3
            col_prio_chk: assert (act[bin[CODE_W-1:COL_BITS]] &&
                                  ((act >> (int'(bin[CODE_W-1:COL_BITS]) + 1)) == '0))
                else $error("column select is not the highest active column");
        end
    end

endmodule

// File: rtl/therm_gray_dec.sv
module therm_gray_dec #(
    parameter int COL_BITS = therm_gray_pkg::DEF_COL_BITS,
    parameter int SEL_BITS = therm_gray_pkg::DEF_SEL_BITS,
    localparam int CODE_W = COL_BITS + SEL_BITS,
    localparam int NCMP   = 1 << CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCMP-1:0]   therm_in,
    output logic [CODE_W-1:0] gray_out,
    output logic              ovr_out
);
    localparam int NCOL = 1 << SEL_BITS;
    localparam int SZ   = 1 << COL_BITS;

    typedef struct packed {
        logic                active;
        logic [COL_BITS-1:0] code;
    } col_word_t;

    // stage 1: comparator capture on the falling edge
    logic [NCMP-1:0] therm_q;
    always_ff @(negedge clk) begin
        if (rst) therm_q <= '0;
        else     therm_q <= therm_in;
    end

    // bubble vote over the word with a virtual always-on bit at the bottom
    logic [NCMP:0] raw_ext, fix_ext;
    assign raw_ext = {therm_q, 1'b1};

    tg_bubble_fix #(.W(NCMP + 1)) u_fix (
        .raw   (raw_ext),
        .fixed (fix_ext)
    );

    logic [NCMP-1:0] level;
    logic            ovr_c;
    assign level = fix_ext[NCMP-1:0];
    assign ovr_c = fix_ext[NCMP];

    // column encoders
    col_word_t col_c [NCOL];
    genvar c;
    generate
        for (c = 0; c < NCOL; c++) begin : g_col
            logic above;
            if (c == NCOL - 1) begin : g_top
                assign above = 1'b0;
            end else begin : g_mid
                assign above = level[(c+1)*SZ];
            end
            tg_col_enc #(.COL_BITS(COL_BITS)) u_enc (
                .slice  (level[c*SZ +: SZ]),
                .above  (above),
                .code   (col_c[c].code),
                .active (col_c[c].active)
            );
        end
    endgenerate

    // stage 2: column latches on the rising edge
    col_word_t col_q [NCOL];
    logic      ovr_q2;
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NCOL; k++) col_q[k] <= '0;
            ovr_q2 <= 1'b0;
        end else begin
            for (int k = 0; k < NCOL; k++) col_q[k] <= col_c[k];
            ovr_q2 <= ovr_c;
        end
    end

    logic [NCOL-1:0]          act_v;
    logic [NCOL*COL_BITS-1:0] code_v;
    always_comb begin
        for (int k = 0; k < NCOL; k++) begin
            act_v[k]                      = col_q[k].active;
            code_v[k*COL_BITS +: COL_BITS] = col_q[k].code;
        end
    end

    logic [CODE_W-1:0] gray_c;
    tg_col_pick #(.COL_BITS(COL_BITS), .SEL_BITS(SEL_BITS)) u_pick (
        .act   (act_v),
        .codes (code_v),
        .ovr   (ovr_q2),
        .gray  (gray_c)
    );

    // stage 3: output register on the next falling edge
    always_ff @(negedge clk) begin
        if (rst) begin
            gray_out <= '0;
            ovr_out  <= 1'b0;
        end else begin
            gray_out <= gray_c;
            ovr_out  <= ovr_q2;
        end
    end

    localparam logic [CODE_W-1:0] FS_GRAY = {1'b1, {(CODE_W-1){1'b0}}};

    // R4
    ovr_fullscale_chk: assert property (@(negedge clk) disable iff (rst)
        ovr_out |-> (gray_out == FS_GRAY))
        else $error("overrange without full-scale code");

endmodule

// File: tb/therm_gray_dec_tb.sv
module therm_gray_dec_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 23;

    // {true code, flipped bit or -1, expected code, expected overrange}
    localparam int VEC [NV][4] = '{
        '{0,   -1, 0,   0},   // R2
        '{1,   -1, 1,   0},   // R2
        '{63,  -1, 63,  0},   // R3
        '{64,  -1, 64,  0},   // R3
        '{127, -1, 127, 0},   // R3
        '{128, -1, 128, 0},   // R3
        '{191, -1, 191, 0},   // R3
        '{192, -1, 192, 0},   // R3
        '{254, -1, 254, 0},   // R2
        '{255, -1, 255, 0},   // R2
        '{100, 50, 100, 0},   // R5
        '{200, 0,  200, 0},   // R5
        '{64,  61, 64,  0},   // R5
        '{255, 128,255, 0},   // R5
        '{10,  100,10,  0},   // R6
        '{0,   254,0,   0},   // R6
        '{130, 132,130, 0},   // R6
        '{100, 98, 99,  0},   // R7
        '{65,  63, 64,  0},   // R7
        '{127, 128,128, 0},   // R7
        '{0,   1,  1,   0},   // R7
        '{255, 255,255, 1},   // R4
        '{200, 255,200, 0}    // R4
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [255:0] therm = '0;
    logic [7:0] gray_out;
    logic       ovr_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    therm_gray_dec u_dut (
        .clk      (clk),
        .rst      (rst),
        .therm_in (therm),
        .gray_out (gray_out),
        .ovr_out  (ovr_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [255:0] build(input int code, input int flip);
        logic [255:0] v;
        v = '0;
        for (int i = 0; i < 255; i++) if (i < code) v[i] = 1'b1;
        if (flip >= 0) v[flip] = ~v[flip];
        return v;
    endfunction

    function automatic logic [7:0] to_gray(input int b);
        logic [7:0] x;
        x = 8'(b);
        return x ^ (x >> 1);
    endfunction

    task automatic check(input string tag, input logic [7:0] eg, input logic eo);
        checks++;
        if (gray_out !== eg || ovr_out !== eo) begin
            fails++;
            $display("FAIL %s: got gray=%b ovr=%b, expected gray=%b ovr=%b",
                     tag, gray_out, ovr_out, eg, eo);
        end
    endtask

    task automatic apply(input logic [255:0] v);
        @(posedge clk); #1;
        therm = v;
        @(posedge clk);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset state", 8'h00, 1'b0);
        rst = 1'b0;

        for (int n = 0; n < NV; n++) begin
            apply(build(VEC[n][0], VEC[n][1]));
            check($sformatf("R2/R3/R4/R5/R6/R7 vector %0d", n),
                  to_gray(VEC[n][2]), VEC[n][3] != 0);
        end

        // R1 literal Gray values
        apply(build(255, -1)); check("R1 code 255", 8'b10000000, 1'b0);
        apply(build(128, -1)); check("R1 code 128", 8'b11000000, 1'b0);
        apply(build(127, -1)); check("R1 code 127", 8'b01000000, 1'b0);
        apply(build(0,   -1)); check("R1 code 0",   8'b00000000, 1'b0);

        // R8 latency
        apply(build(50, -1));
        @(posedge clk); #1;
        therm = build(200, -1);
        @(posedge clk); #1;
        check("R8 previous sample held", to_gray(50), 1'b0);
        @(posedge clk); #1;
        check("R8 new sample after one cycle", to_gray(200), 1'b0);

        // R9 reset during operation
        apply(build(255, 255));
        check("R4 overrange before reset", 8'b10000000, 1'b1);
        rst = 1'b1;
        @(posedge clk); #1;
        check("R9 reset mid-run", 8'h00, 1'b0);
        rst = 1'b0;

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R8: got no completion, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule